// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache placed between a requester that reads bytes and a slower backing memory that delivers whole lines. A byte address is split into three fields. The low bits choose a byte inside a line. The next bits choose one of the sets. The remaining upper bits form the tag that is stored beside each line. Every set holds two lines, called ways. The two ways of the selected set are compared against the tag at the same time, and a 2-to-1 selector passes the matching way's line on to the byte selector.

On a miss the block stalls the requester by holding `busy` high and asks the backing memory for the whole line with a request/valid handshake. The memory returns the line in a single beat. The returned line is written into a victim way. An empty way is always used first. When both ways are occupied, the victim is the way that was used least recently, which one bit per set tracks. The requested byte goes back to the requester in the same refill step.

Top module: `twoway_rd_cache`

## Requirements
- R1: The low OFF_W address bits select the byte in the line (byte i is `mem_line[8i+7:8i]`), the next SET_W bits select the set, and the upper bits are the tag. `mem_addr` carries the block address, `req_addr >> OFF_W`. With the defaults, address 6195 (0x1833) is block 0x183 in set 3.
- R2: After reset, `busy`, `rsp_valid` and `mem_req` are low and every way is empty, so the first read to any set misses.
- R3: A hit gives a one-cycle `rsp_valid` pulse two clock edges after the request is accepted. `rsp_data` holds the addressed byte, and `mem_req` stays low.
- R4: A miss raises `mem_req` from the edge after acceptance. `mem_req` holds a stable `mem_addr`, with `busy` high, until an edge samples `mem_valid`.
- R5: At the edge that samples `mem_valid` during a miss, the byte at the request offset in `mem_line` is returned with `rsp_valid` and `busy` drops. The line, tag and valid flag are stored, so a later read of that block hits.
- R6: Two blocks that map to the same set can be resident together, and both hit.
- R7: A refill uses an empty way before it evicts anything, and way 0 is used when both ways are empty. After blocks A and then B fill a set, a third block C replaces A.
- R8: Each set's replacement bit names the way to evict next. Every hit and every refill sets it to the other way. After A, B, a hit on A, and then C, the block C replaces B.
- R9: A tag never matches in both ways of a set at once. A hit never loads a second copy of a line.
- R10: A request is accepted only while `busy` is low. A request presented while `busy` is high has no effect, and `rsp_valid` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request, taken when busy is low |
| req_addr | input | ADDR_W | Byte address of the read |
| busy | output | 1 | Stall: the block is looking up or refilling |
| rsp_valid | output | 1 | One-cycle pulse, rsp_data is valid |
| rsp_data | output | BYTE_W | Byte that was read |
| mem_req | output | 1 | Line request to the backing memory |
| mem_addr | output | ADDR_W-OFF_W | Block address of the requested line |
| mem_valid | input | 1 | Backing memory presents the line this cycle |
| mem_line | input | BYTE_W<<OFF_W | Whole line from the backing memory |

## Verification
Directed sequences within one set tell the replacement orders apart. A, B, C shows that an empty way fills first and that a refill updates the order. A, B, a hit on A, then C shows that a hit moves the order. A repeated hit shows that no second copy is ever loaded. The worked address 6195 and the accesses straight after reset check the field split and the empty initial state. A request held high during a refill shows that requests are ignored while busy. A seeded random stream over three tags, all sets and all offsets then makes frequent conflicts. Every response byte and every hit-or-miss outcome is compared against a bench model of the sets and replacement bits, with memory latencies that vary.

// File: rtl/c2_cache_pkg.sv
package c2_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MISS = 2'd2
  } c2_state_t;
endpackage

// File: rtl/c2_line_ram.sv
module c2_line_ram #(
  parameter int SET_W  = 2,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              re,
  input  logic [SET_W-1:0]  rd_set,
  output logic [LINE_W-1:0] rd_line,
  input  logic              we,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << SET_W;

  logic [LINE_W-1:0] store [SETS];

  always_ff @(posedge clk) begin
    if (we) store[wr_set] <= wr_line;
    if (re) rd_line <= store[rd_set];
  end
endmodule

// File: rtl/c2_tag_bank.sv
module c2_tag_bank #(
  parameter int SET_W = 2,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             hit,
  output logic             vld_o,
  input  logic             we,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0] tags [SETS];
  logic [SETS-1:0]  vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (we) vld[wr_set] <= 1'b1;
    if (we) tags[wr_set] <= wr_tag;
  end

  assign vld_o = vld[rd_set];
  assign hit   = vld[rd_set] && (tags[rd_set] == cmp_tag);

  // R2
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld == '0));
endmodule

// File: rtl/c2_lru_bits.sv
module c2_lru_bits #(
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic             evict_way,
  input  logic             upd,
  input  logic [SET_W-1:0] upd_set,
  input  logic             used_way
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else if (upd) bits[upd_set] <= ~used_way;
  end

  assign evict_way = bits[rd_set];

  // R8
  lru_flip_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> (bits[$past(upd_set)] != $past(used_way)));
endmodule

// File: rtl/twoway_rd_cache.sv
module twoway_rd_cache
  import c2_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 2,
  parameter int OFF_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          busy,
  output logic                          rsp_valid,
  output logic [BYTE_W-1:0]             rsp_data,
  output logic                          mem_req,
  output logic [ADDR_W-OFF_W-1:0]       mem_addr,
  input  logic                          mem_valid,
  input  logic [(BYTE_W<<OFF_W)-1:0]    mem_line
);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int BYTES  = 1 << OFF_W;
  localparam int LINE_W = BYTE_W * BYTES;

  c2_state_t          st;
  logic [ADDR_W-1:0]  a_q;
  logic [SET_W-1:0]   set_in, set_q;
  logic [TAG_W-1:0]   tag_q;
  logic [OFF_W-1:0]   off_q;
  logic               accept, refill, lookup_hit, hit_way, victim, lru_way;
  logic [1:0]         hit, vld, wr_en;
  logic [LINE_W-1:0]  rd_line [2];
  logic [LINE_W-1:0]  sel_line;

  assign set_in = req_addr[OFF_W +: SET_W];
  assign set_q  = a_q[OFF_W +: SET_W];
  assign tag_q  = a_q[ADDR_W-1 -: TAG_W];
  assign off_q  = a_q[OFF_W-1:0];

  assign accept     = req_valid && (st == ST_IDLE);
  assign refill     = (st == ST_MISS) && mem_valid;
  assign lookup_hit = (st == ST_LOOK) && (hit != 2'b00);
  assign hit_way    = hit[1];
  assign victim     = !vld[0] ? 1'b0 : (!vld[1] ? 1'b1 : lru_way);
  assign wr_en[0]   = refill && !victim;
  assign wr_en[1]   = refill && victim;
  assign sel_line   = hit_way ? rd_line[1] : rd_line[0];

  for (genvar w = 0; w < 2; w++) begin : g_way
    c2_tag_bank #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst(rst), .rd_set(set_q), .cmp_tag(tag_q),
      .hit(hit[w]), .vld_o(vld[w]),
      .we(wr_en[w]), .wr_set(set_q), .wr_tag(tag_q)
    );
    c2_line_ram #(.SET_W(SET_W), .LINE_W(LINE_W)) u_data (
      .clk(clk), .re(accept), .rd_set(set_in), .rd_line(rd_line[w]),
      .we(wr_en[w]), .wr_set(set_q), .wr_line(mem_line)
    );
  end

  c2_lru_bits #(.SET_W(SET_W)) u_lru (
    .clk(clk), .rst(rst), .rd_set(set_q), .evict_way(lru_way),
    .upd(lookup_hit || refill), .upd_set(set_q),
    .used_way(refill ? victim : hit_way)
  );

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [LINE_W-1:0] ln,
                                                  input logic [OFF_W-1:0] off);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int b = 0; b < BYTES; b++)
      if (off == OFF_W'(b)) r = ln[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      a_q       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          a_q <= req_addr;
          st  <= ST_LOOK;
        end
        ST_LOOK: if (hit != 2'b00) begin
          rsp_valid <= 1'b1;
          rsp_data  <= pick_byte(sel_line, off_q);
          st        <= ST_IDLE;
        end else begin
          st <= ST_MISS;
        end
        ST_MISS: if (mem_valid) begin
          rsp_valid <= 1'b1;
          rsp_data  <= pick_byte(mem_line, off_q);
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign mem_req  = (st == ST_MISS);
  assign mem_addr = a_q[ADDR_W-1:OFF_W];

  // R9
  dual_match_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK) |-> !(hit[0] && hit[1]));
  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && busy && $stable(mem_addr)));
  // R5
  refill_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_valid) |=> (rsp_valid && !busy));
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);
endmodule

// File: tb/twoway_rd_cache_test.sv
`timescale 1ns/1ps
module twoway_rd_cache_test;
  localparam int ADDR_W = 16, SET_W = 2, OFF_W = 4, BYTE_W = 8;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int SETS = 1 << SET_W;
  localparam int LINE_W = BYTE_W << OFF_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic busy, rsp_valid, mem_req;
  logic [BYTE_W-1:0] rsp_data;
  logic [ADDR_W-OFF_W-1:0] mem_addr;
  logic mem_valid = 1'b0;
  logic [LINE_W-1:0] mem_line = '0;

  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  twoway_rd_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_line(mem_line)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // backing memory content
  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return 8'(a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [LINE_W-1:0] mline(input logic [ADDR_W-OFF_W-1:0] blk);
    logic [LINE_W-1:0] l;
    for (int b = 0; b < (1 << OFF_W); b++) l[b*8 +: 8] = mbyte({blk, OFF_W'(b)});
    return l;
  endfunction

  // reference model of the sets
  logic [TAG_W-1:0] m_tag [SETS][2];
  logic             m_vld [SETS][2];
  logic             m_lru [SETS];

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      m_vld[s][0] = 0; m_vld[s][1] = 0; m_lru[s] = 0;
    end
  endtask

  function automatic bit model_access(input logic [ADDR_W-1:0] a);
    logic [SET_W-1:0] s;
    logic [TAG_W-1:0] t;
    bit v;
    s = a[OFF_W +: SET_W];
    t = a[ADDR_W-1 -: TAG_W];
    for (int w = 0; w < 2; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin
        m_lru[s] = ~1'(w);
        return 1;
      end
    v = !m_vld[s][0] ? 1'b0 : (!m_vld[s][1] ? 1'b1 : m_lru[s]);
    m_vld[s][v] = 1; m_tag[s][v] = t; m_lru[s] = ~v;
    return 0;
  endfunction

  // one read; junk = hold another request while busy
  task automatic do_read(input logic [ADDR_W-1:0] a, input bit junk, input int dly,
                         output bit was_hit);
    bit exp_hit, done, saw_mem;
    int lat;
    exp_hit = model_access(a);
    done = 0; saw_mem = 0; lat = 0;
    @(negedge clk); req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
    while (!done && lat < 40) begin
      @(negedge clk); lat++;
      if (rsp_valid) begin
        done = 1;
        check(lat == 1, "R3 hit latency", lat, 1);
        check(rsp_data == mbyte(a), "R3 hit byte", rsp_data, mbyte(a));
      end else if (mem_req) begin
        saw_mem = 1;
        check(mem_addr == a[ADDR_W-1:OFF_W], "R1 block address", mem_addr, a[ADDR_W-1:OFF_W]);
        check(busy, "R4 busy during miss", busy, 1);
        if (junk) begin req_valid = 1; req_addr = a ^ 16'h0400; end
        repeat (dly) @(negedge clk);
        check(mem_req && mem_addr == a[ADDR_W-1:OFF_W], "R4 request held", mem_addr, a[ADDR_W-1:OFF_W]);
        mem_valid = 1; mem_line = mline(a[ADDR_W-1:OFF_W]);
        @(negedge clk);
        mem_valid = 0; req_valid = 0;
        done = 1;
        check(rsp_valid && !busy, "R5 refill response", {rsp_valid, busy}, 2'b10);
        check(rsp_data == mbyte(a), "R5 refill byte", rsp_data, mbyte(a));
      end
    end
    check(done, "R3 response seen", done, 1);
    was_hit = !saw_mem;
    check(was_hit == exp_hit, "R6 hit/miss vs model", was_hit, exp_hit);
    if (junk) begin
      repeat (3) begin
        @(negedge clk);
        check(!rsp_valid && !mem_req && !busy, "R10 busy request ignored",
              {rsp_valid, mem_req, busy}, 0);
      end
    end
  endtask

  initial begin
    bit h;
    logic [ADDR_W-1:0] ra, rb, rc;
    void'($urandom(32'd20240607));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !rsp_valid && !mem_req, "R2 reset outputs", {busy, rsp_valid, mem_req}, 0);

    // R2: first access after reset misses; R1 worked example 6195
    do_read(16'd6195, 0, 1, h);
    check(!h, "R2 first read misses", h, 0);
    check(16'd6195 >> OFF_W == 16'h0183 && 16'd6195 % 64 / 16 == 3, "R1 worked split", 16'd6195 >> 4, 16'h183);
    do_read(16'd6195 ^ 16'h000A, 0, 1, h);
    check(h, "R5 same block hits", h, 1);
    do_read(16'd6195, 0, 1, h);
    check(h, "R9 hit does not reload", h, 1);

    // R7: A, B, C in set 1 -> C replaces A
    ra = 16'h0050; rb = 16'h0093; rc = 16'h00D7;
    do_read(ra, 0, 2, h); check(!h, "R7 A miss", h, 0);
    do_read(rb, 0, 0, h); check(!h, "R7 B miss", h, 0);
    do_read(ra, 0, 0, h); check(h, "R6 A resident with B", h, 1);
    do_read(rb, 0, 0, h); check(h, "R6 B resident with A", h, 1);
    // order now: B most recent -> C evicts A (R8/R7)
    do_read(rc, 0, 1, h); check(!h, "R7 C miss", h, 0);
    do_read(rb, 0, 0, h); check(h, "R7 B kept", h, 1);
    do_read(ra, 0, 0, h); check(!h, "R7 A evicted", h, 0);
    // now A replaced C (LRU after hit on B). hit A? resident: B, A. hit B then C evicts A
    do_read(rb, 0, 0, h); check(h, "R8 hit on B", h, 1);
    do_read(rc, 0, 3, h); check(!h, "R8 C miss", h, 0);
    do_read(rb, 0, 0, h); check(h, "R8 B kept after hit", h, 1);
    do_read(ra, 0, 0, h); check(!h, "R8 A evicted", h, 0);

    // R10: request held while busy is ignored
    do_read(16'h3A2F, 1, 2, h);

    // random stream
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      a = {TAG_W'($urandom % 3), SET_W'($urandom), OFF_W'($urandom)};
      do_read(a, ($urandom % 16) == 0, int'($urandom % 4), h);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule